// File: doc/BRIEF.md
# Bus Trigger and Capture Debug Unit

This unit watches the CPU bus on every cycle (address, data byte, read/write direction, opcode-fetch marker and change-of-flow marker). Two comparators, A and B, look at it, and one of nine selectable trigger modes decides when a trigger event has happened. The modes are single matches, sequenced A-then-B, address-plus-data qualifiers, address ranges and two event-storage modes. A small capture FIFO records either change-of-flow addresses, from the trigger onward, or data bytes, one per event, depending on the mode.

On its first trigger after arming, the unit can request a breakpoint. A force breakpoint is raised at once. A tag breakpoint is attached to an opcode fetch and is raised only when that opcode is reported as executed. Configuration is applied through static inputs, plus one-cycle arm and disarm strobes. A debug host drains the FIFO through a pop strobe.

Top module: `dbg_trace_unit`

## Requirements
- R1: After reset the FIFO is empty (count 0, full low), the unit is disarmed, the trigger flag is low and both breakpoint requests are low.
- R2: Mode 0 (A only) triggers on a valid cycle whose address equals A, qualified by the A direction when its enable is set (rd 1 = read). Mode 1 triggers on an A or a B match. The trigger flag rises at the clock edge that ends the matching cycle, stays high until the next arm, and never rises while disarmed.
- R3: Mode 2 (A then B) triggers only on a B match in a cycle after an A match seen while armed. A B match before A is ignored. Disarm or arm clears the sequencer.
- R4: Mode 3 triggers on an A address match whose data byte equals the B data value. Mode 4 triggers on an A address match whose data differs from it.
- R5: Mode 7 triggers when A <= address <= B, with both bounds inclusive. Mode 8 triggers when the address is below A or above B.
- R6: In all modes other than 5 and 6, the full 16-bit address of every change-of-flow cycle is pushed into the FIFO, starting with the trigger cycle itself. Cycles without the change-of-flow marker are not stored.
- R7: Mode 5 pushes {8'h00, data} on every B match and triggers on the first one. Mode 6 does the same, but only for B matches after an A match.
- R8: The FIFO holds 8 entries. At 8 entries the full flag is high and further pushes are dropped. The read port shows the oldest entry, and a pop removes it.
- R9: With breakpoints enabled in force kind, a one-cycle force request follows the first trigger after arming. It is visible in the cycle after the trigger cycle.
- R10: With breakpoints enabled in tag kind, a first trigger on an opcode-fetch cycle tags that address. A tag request pulses for one cycle after an execute strobe whose address equals the tagged one. No request follows a trigger on a non-fetch cycle or an execute strobe of another address.
- R11: Arm empties the FIFO, clears the trigger flag and resets the sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 8 | Bus data byte |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_fetch | input | 1 | Cycle is an opcode fetch |
| bus_cof | input | 1 | Cycle is a change-of-flow target |
| exec_strobe | input | 1 | An opcode reached execution |
| exec_addr | input | 16 | Address of the executed opcode |
| cmp_a_addr | input | 16 | Comparator A address / lower range bound |
| cmp_a_dir_en | input | 1 | Qualify A on direction |
| cmp_a_dir | input | 1 | Required direction for A |
| cmp_b_addr | input | 16 | Comparator B address / upper range bound |
| cmp_b_dir_en | input | 1 | Qualify B on direction |
| cmp_b_dir | input | 1 | Required direction for B |
| cmp_b_data | input | 8 | Data value for modes 3 and 4 |
| trig_mode | input | 4 | Trigger mode 0..8 (others never trigger) |
| brk_en | input | 1 | Breakpoint request enable |
| brk_tag | input | 1 | 1 = tag kind, 0 = force kind |
| arm | input | 1 | Arm strobe |
| disarm | input | 1 | Disarm strobe |
| fifo_pop | input | 1 | Remove oldest FIFO entry |
| fifo_dout | output | 16 | Oldest FIFO entry |
| fifo_cnt | output | 4 | FIFO entries held |
| fifo_full | output | 1 | FIFO holds 8 entries |
| armed | output | 1 | Unit is armed |
| trig_flag | output | 1 | Trigger has occurred since arming |
| brk_force_req | output | 1 | Force breakpoint request pulse |
| brk_tag_req | output | 1 | Tag breakpoint request pulse |

## Verification
A sequencer stuck in its waiting state makes mode 2 trigger on a lone B match, or miss one, and this shows on the trigger flag one edge after the offending cycle. Bad FIFO pointers or a bad count show at once as a wrong count or full flag, or, on the next pop, as entries returned out of order or with the wrong content. A mishandled tag shows as a request pulse after an execute strobe of the wrong address, or as no pulse after the right one, one edge after the strobe.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [3:0] {
    MD_A        = 4'd0,
    MD_A_OR_B   = 4'd1,
    MD_A_THEN_B = 4'd2,
    MD_A_AND_D  = 4'd3,
    MD_A_NOT_D  = 4'd4,
    MD_EV_B     = 4'd5,
    MD_A_THEN_EV= 4'd6,
    MD_IN_RNG   = 4'd7,
    MD_OUT_RNG  = 4'd8
  } trig_mode_e;
endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rd,
  input  logic [AW-1:0] a_addr,
  input  logic          a_dir_en,
  input  logic          a_dir,
  input  logic [AW-1:0] b_addr,
  input  logic          b_dir_en,
  input  logic          b_dir,
  input  logic [DW-1:0] b_data,
  output logic          a_hit,
  output logic          b_hit,
  output logic          d_eq,
  output logic          in_rng,
  output logic          out_rng
);
  logic a_dir_ok, b_dir_ok;

  always_comb begin
    a_dir_ok = !a_dir_en || (bus_rd == a_dir);
    b_dir_ok = !b_dir_en || (bus_rd == b_dir);
    a_hit    = bus_valid && (bus_addr == a_addr) && a_dir_ok;
    b_hit    = bus_valid && (bus_addr == b_addr) && b_dir_ok;
    d_eq     = (bus_data == b_data);
    in_rng   = bus_valid && (bus_addr >= a_addr) && (bus_addr <= b_addr);
    out_rng  = bus_valid && ((bus_addr < a_addr) || (bus_addr > b_addr));
  end
endmodule

// File: rtl/dbg_ctl.sv
module dbg_ctl
  import dbg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode_i,
  input  logic          arm,
  input  logic          disarm,
  input  logic          bus_valid,
  input  logic          bus_cof,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          a_hit,
  input  logic          b_hit,
  input  logic          d_eq,
  input  logic          in_rng,
  input  logic          out_rng,
  output logic          push,
  output logic [AW-1:0] push_data,
  output logic          first_trig,
  output logic          armed_q,
  output logic          trig_q
);
  trig_mode_e mode;
  logic seq_q, seq_d, armed_d, trig_d;
  logic hit_now, ev, ev_mode, seq_mode, hit;

  always_comb begin
    mode     = trig_mode_e'(mode_i);
    hit_now  = 1'b0;
    ev       = 1'b0;
    ev_mode  = (mode == MD_EV_B) || (mode == MD_A_THEN_EV);
    seq_mode = (mode == MD_A_THEN_B) || (mode == MD_A_THEN_EV);
    case (mode)
      MD_A:         hit_now = a_hit;
      MD_A_OR_B:    hit_now = a_hit || b_hit;
      MD_A_THEN_B:  hit_now = seq_q && b_hit;
      MD_A_AND_D:   hit_now = a_hit && d_eq;
      MD_A_NOT_D:   hit_now = a_hit && !d_eq;
      MD_EV_B:      ev      = b_hit;
      MD_A_THEN_EV: ev      = seq_q && b_hit;
      MD_IN_RNG:    hit_now = in_rng;
      MD_OUT_RNG:   hit_now = out_rng;
      default:      hit_now = 1'b0;
    endcase
    hit        = hit_now || ev;
    first_trig = armed_q && hit && !trig_q;
    push       = armed_q && (ev_mode ? ev : (bus_valid && bus_cof && (trig_q || hit_now)));
    push_data  = ev_mode ? {{(AW-DW){1'b0}}, bus_data} : bus_addr;

    armed_d = armed_q;
    if (arm)         armed_d = 1'b1;
    else if (disarm) armed_d = 1'b0;

    trig_d = trig_q;
    if (arm)                  trig_d = 1'b0;
    else if (armed_q && hit)  trig_d = 1'b1;

    seq_d = seq_q;
    if (arm || disarm)                        seq_d = 1'b0;
    else if (armed_q && seq_mode && a_hit)    seq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      trig_q  <= 1'b0;
      seq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      trig_q  <= trig_d;
      seq_q   <= seq_d;
    end
  end

  // R2: the trigger flag can only rise while armed
  a_r2_trig_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_q) |-> $past(armed_q));
  // R3: disarm always clears the sequencer
  a_r3_seq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> !seq_q);
endmodule

// File: rtl/dbg_fifo.sv
module dbg_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    do_push = push && (cnt_q != CW'(DEPTH));
    do_pop  = pop && (cnt_q != '0);
    wr_d    = wr_q;
    rd_d    = rd_q;
    cnt_d   = cnt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = inc_ptr(wr_q);
      if (do_pop)  rd_d = inc_ptr(rd_q);
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!flush && do_push && (wr_q == PW'(i))) mem[i] <= pdata;
      end
    end
  endgenerate

  assign dout = mem[rd_q];
  assign cnt  = cnt_q;
  assign full = (cnt_q == CW'(DEPTH));

  // R8: occupancy never exceeds the depth
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R8: a full FIFO stays full without pop or flush
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full);
endmodule

// File: rtl/dbg_brk.sv
module dbg_brk #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          first_trig,
  input  logic          brk_en,
  input  logic          brk_tag,
  input  logic          bus_fetch,
  input  logic [AW-1:0] bus_addr,
  input  logic          exec_strobe,
  input  logic [AW-1:0] exec_addr,
  output logic          force_req,
  output logic          tag_req
);
  logic          pend_q, pend_d, force_q, force_d, tag_q, tag_d;
  logic [AW-1:0] tag_addr_q, tag_addr_d;
  logic          tag_ld, tag_fire;

  always_comb begin
    tag_ld     = brk_en && brk_tag && first_trig && bus_fetch;
    tag_fire   = pend_q && exec_strobe && (exec_addr == tag_addr_q);
    force_d    = brk_en && !brk_tag && first_trig;
    tag_d      = tag_fire && !clear;
    pend_d     = pend_q;
    tag_addr_d = tag_addr_q;
    if (clear)         pend_d = 1'b0;
    else if (tag_ld) begin
      pend_d     = 1'b1;
      tag_addr_d = bus_addr;
    end else if (tag_fire) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      force_q    <= 1'b0;
      tag_q      <= 1'b0;
      tag_addr_q <= '0;
    end else begin
      pend_q     <= pend_d;
      force_q    <= force_d;
      tag_q      <= tag_d;
      if (tag_ld && !clear) tag_addr_q <= tag_addr_d;
    end
  end

  assign force_req = force_q;
  assign tag_req   = tag_q;

  // R9: a force request is a single-cycle pulse
  a_r9_force_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |=> !force_q);
  // R10: a tag request needs a pending tag in the prior cycle
  a_r10_tag_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    tag_q |-> $past(pend_q));
endmodule

// File: rtl/dbg_trace_unit.sv
module dbg_trace_unit #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rd,
  input  logic          bus_fetch,
  input  logic          bus_cof,
  input  logic          exec_strobe,
  input  logic [AW-1:0] exec_addr,
  input  logic [AW-1:0] cmp_a_addr,
  input  logic          cmp_a_dir_en,
  input  logic          cmp_a_dir,
  input  logic [AW-1:0] cmp_b_addr,
  input  logic          cmp_b_dir_en,
  input  logic          cmp_b_dir,
  input  logic [DW-1:0] cmp_b_data,
  input  logic [3:0]    trig_mode,
  input  logic          brk_en,
  input  logic          brk_tag,
  input  logic          arm,
  input  logic          disarm,
  input  logic          fifo_pop,
  output logic [AW-1:0] fifo_dout,
  output logic [CW-1:0] fifo_cnt,
  output logic          fifo_full,
  output logic          armed,
  output logic          trig_flag,
  output logic          brk_force_req,
  output logic          brk_tag_req
);
  logic [1:0]    rst_sync;
  logic          rst_i_n;
  logic          a_hit, b_hit, d_eq, in_rng, out_rng;
  logic          push, first_trig;
  logic [AW-1:0] push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  dbg_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data), .bus_rd(bus_rd),
    .a_addr(cmp_a_addr), .a_dir_en(cmp_a_dir_en), .a_dir(cmp_a_dir),
    .b_addr(cmp_b_addr), .b_dir_en(cmp_b_dir_en), .b_dir(cmp_b_dir), .b_data(cmp_b_data),
    .a_hit(a_hit), .b_hit(b_hit), .d_eq(d_eq), .in_rng(in_rng), .out_rng(out_rng)
  );

  dbg_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_i_n), .mode_i(trig_mode), .arm(arm), .disarm(disarm),
    .bus_valid(bus_valid), .bus_cof(bus_cof), .bus_addr(bus_addr), .bus_data(bus_data),
    .a_hit(a_hit), .b_hit(b_hit), .d_eq(d_eq), .in_rng(in_rng), .out_rng(out_rng),
    .push(push), .push_data(push_data), .first_trig(first_trig),
    .armed_q(armed), .trig_q(trig_flag)
  );

  dbg_fifo #(.W(AW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .flush(arm), .push(push), .pdata(push_data),
    .pop(fifo_pop), .dout(fifo_dout), .cnt(fifo_cnt), .full(fifo_full)
  );

  dbg_brk #(.AW(AW)) u_brk (
    .clk(clk), .rst_n(rst_i_n), .clear(arm || disarm), .first_trig(first_trig),
    .brk_en(brk_en), .brk_tag(brk_tag), .bus_fetch(bus_fetch), .bus_addr(bus_addr),
    .exec_strobe(exec_strobe), .exec_addr(exec_addr),
    .force_req(brk_force_req), .tag_req(brk_tag_req)
  );
endmodule

// File: tb/dbg_trace_unit_tb_top.sv
module dbg_trace_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_rd, bus_fetch, bus_cof, exec_strobe;
  logic [15:0] bus_addr, exec_addr, cmp_a_addr, cmp_b_addr;
  logic [7:0]  bus_data, cmp_b_data;
  logic        cmp_a_dir_en, cmp_a_dir, cmp_b_dir_en, cmp_b_dir;
  logic [3:0]  trig_mode;
  logic        brk_en, brk_tag, arm, disarm, fifo_pop;
  logic [15:0] fifo_dout;
  logic [3:0]  fifo_cnt;
  logic        fifo_full, armed, trig_flag, brk_force_req, brk_tag_req;
  int          errors = 0, checks = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  dbg_trace_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_rd(bus_rd), .bus_fetch(bus_fetch), .bus_cof(bus_cof),
    .exec_strobe(exec_strobe), .exec_addr(exec_addr),
    .cmp_a_addr(cmp_a_addr), .cmp_a_dir_en(cmp_a_dir_en), .cmp_a_dir(cmp_a_dir),
    .cmp_b_addr(cmp_b_addr), .cmp_b_dir_en(cmp_b_dir_en), .cmp_b_dir(cmp_b_dir),
    .cmp_b_data(cmp_b_data), .trig_mode(trig_mode), .brk_en(brk_en), .brk_tag(brk_tag),
    .arm(arm), .disarm(disarm), .fifo_pop(fifo_pop), .fifo_dout(fifo_dout),
    .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .armed(armed), .trig_flag(trig_flag),
    .brk_force_req(brk_force_req), .brk_tag_req(brk_tag_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic rd,
                     input logic fetch, input logic cof);
    bus_valid = 1; bus_addr = a; bus_data = d; bus_rd = rd; bus_fetch = fetch; bus_cof = cof;
    @(negedge clk);
    bus_valid = 0; bus_fetch = 0; bus_cof = 0;
  endtask

  task automatic do_arm();
    arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic do_disarm();
    disarm = 1; @(negedge clk); disarm = 0;
  endtask

  task automatic do_exec(input logic [15:0] a);
    exec_strobe = 1; exec_addr = a; @(negedge clk); exec_strobe = 0;
  endtask

  task automatic pop_chk(input string req, input logic [15:0] exp);
    chk(req, fifo_dout, exp);
    fifo_pop = 1; @(negedge clk); fifo_pop = 0;
  endtask

  task automatic t_reset();
    chk("R1 cnt", 16'(fifo_cnt), 0);
    chk("R1 full", 16'(fifo_full), 0);
    chk("R1 armed", 16'(armed), 0);
    chk("R1 trig", 16'(trig_flag), 0);
    chk("R1 brk", 16'({brk_force_req, brk_tag_req}), 0);
  endtask

  task automatic t_single();
    trig_mode = 0; cmp_a_addr = 16'h1234; cmp_a_dir_en = 1; cmp_a_dir = 1;
    cyc(16'h1234, 8'h00, 1, 0, 0);
    chk("R2 disarmed no trig", 16'(trig_flag), 0);
    do_arm();
    cyc(16'h1234, 8'h00, 0, 0, 0);
    chk("R2 wrong dir", 16'(trig_flag), 0);
    cyc(16'h1234, 8'h00, 1, 0, 0);
    chk("R2 A match", 16'(trig_flag), 1);
    cyc(16'h0001, 8'h00, 1, 0, 0);
    chk("R2 sticky", 16'(trig_flag), 1);
    trig_mode = 1; cmp_b_addr = 16'h2000; cmp_b_dir_en = 0;
    do_arm();
    chk("R11 arm clears trig", 16'(trig_flag), 0);
    cyc(16'h2000, 8'h00, 0, 0, 0);
    chk("R2 A or B via B", 16'(trig_flag), 1);
    cmp_a_dir_en = 0;
  endtask

  task automatic t_seq();
    trig_mode = 2; cmp_a_addr = 16'h0100; cmp_b_addr = 16'h0200;
    do_arm();
    cyc(16'h0200, 8'h00, 1, 0, 0);
    chk("R3 B before A", 16'(trig_flag), 0);
    cyc(16'h0100, 8'h00, 1, 0, 0);
    chk("R3 A alone", 16'(trig_flag), 0);
    cyc(16'h0200, 8'h00, 1, 0, 0);
    chk("R3 A then B", 16'(trig_flag), 1);
    do_arm();
    cyc(16'h0100, 8'h00, 1, 0, 0);
    do_disarm();
    do_arm();
    cyc(16'h0200, 8'h00, 1, 0, 0);
    chk("R3 disarm resets seq", 16'(trig_flag), 0);
  endtask

  task automatic t_data();
    trig_mode = 3; cmp_a_addr = 16'h0300; cmp_b_data = 8'h5A;
    do_arm();
    cyc(16'h0300, 8'h11, 1, 0, 0);
    chk("R4 A and data mismatch", 16'(trig_flag), 0);
    cyc(16'h0300, 8'h5A, 1, 0, 0);
    chk("R4 A and data", 16'(trig_flag), 1);
    trig_mode = 4;
    do_arm();
    cyc(16'h0300, 8'h5A, 1, 0, 0);
    chk("R4 A and not data eq", 16'(trig_flag), 0);
    cyc(16'h0300, 8'h11, 1, 0, 0);
    chk("R4 A and not data", 16'(trig_flag), 1);
  endtask

  task automatic t_range();
    trig_mode = 7; cmp_a_addr = 16'h0400; cmp_b_addr = 16'h040F;
    do_arm();
    cyc(16'h03FF, 8'h00, 1, 0, 0);
    chk("R5 below range", 16'(trig_flag), 0);
    cyc(16'h040F, 8'h00, 1, 0, 0);
    chk("R5 upper bound in", 16'(trig_flag), 1);
    do_arm();
    cyc(16'h0400, 8'h00, 1, 0, 0);
    chk("R5 lower bound in", 16'(trig_flag), 1);
    trig_mode = 8;
    do_arm();
    cyc(16'h0400, 8'h00, 1, 0, 0);
    cyc(16'h040F, 8'h00, 1, 0, 0);
    chk("R5 outside not on bounds", 16'(trig_flag), 0);
    cyc(16'h0410, 8'h00, 1, 0, 0);
    chk("R5 above", 16'(trig_flag), 1);
    do_arm();
    cyc(16'h03FF, 8'h00, 1, 0, 0);
    chk("R5 below", 16'(trig_flag), 1);
  endtask

  task automatic t_cof();
    trig_mode = 0; cmp_a_addr = 16'h0500;
    do_arm();
    cyc(16'h0600, 8'h00, 1, 0, 1);
    chk("R6 no capture before trig", 16'(fifo_cnt), 0);
    cyc(16'h0500, 8'h00, 1, 0, 1);
    chk("R6 trig cycle captured", 16'(fifo_cnt), 1);
    cyc(16'h0650, 8'h00, 1, 0, 0);
    chk("R6 non-cof not stored", 16'(fifo_cnt), 1);
    for (int i = 0; i < 9; i++) cyc(16'h0700 + 16'(i), 8'h00, 1, 0, 1);
    chk("R8 count at depth", 16'(fifo_cnt), 8);
    chk("R8 full", 16'(fifo_full), 1);
    pop_chk("R8 oldest", 16'h0500);
    chk("R8 not full after pop", 16'(fifo_full), 0);
    for (int i = 0; i < 7; i++) pop_chk("R8 order", 16'h0700 + 16'(i));
    chk("R8 empty", 16'(fifo_cnt), 0);
  endtask

  task automatic t_event();
    trig_mode = 5; cmp_b_addr = 16'h0800;
    do_arm();
    cyc(16'h0800, 8'h33, 1, 0, 0);
    chk("R7 event count", 16'(fifo_cnt), 1);
    chk("R7 event trig", 16'(trig_flag), 1);
    cyc(16'h0801, 8'h44, 1, 0, 1);
    chk("R7 non-B ignored", 16'(fifo_cnt), 1);
    cyc(16'h0800, 8'h55, 0, 0, 0);
    chk("R7 second event", 16'(fifo_cnt), 2);
    pop_chk("R7 data 1", 16'h0033);
    pop_chk("R7 data 2", 16'h0055);
    trig_mode = 6; cmp_a_addr = 16'h0900;
    do_arm();
    cyc(16'h0800, 8'h66, 1, 0, 0);
    chk("R7 B before A", 16'(fifo_cnt), 0);
    cyc(16'h0900, 8'h00, 1, 0, 0);
    chk("R7 A not stored", 16'(fifo_cnt), 0);
    cyc(16'h0800, 8'h77, 1, 0, 0);
    chk("R7 B after A", 16'(fifo_cnt), 1);
    chk("R7 seq trig", 16'(trig_flag), 1);
    pop_chk("R7 seq data", 16'h0077);
  endtask

  task automatic t_force();
    trig_mode = 0; cmp_a_addr = 16'h0A00; brk_en = 1; brk_tag = 0;
    do_arm();
    cyc(16'h0A00, 8'h00, 1, 0, 0);
    chk("R9 force pulse", 16'(brk_force_req), 1);
    @(negedge clk);
    chk("R9 force one cycle", 16'(brk_force_req), 0);
    cyc(16'h0A00, 8'h00, 1, 0, 0);
    chk("R9 only first trig", 16'(brk_force_req), 0);
  endtask

  task automatic t_tag();
    trig_mode = 0; cmp_a_addr = 16'h0B00; brk_en = 1; brk_tag = 1;
    do_arm();
    cyc(16'h0B00, 8'h00, 1, 1, 0);
    chk("R10 no req at fetch", 16'(brk_tag_req), 0);
    chk("R10 no force in tag", 16'(brk_force_req), 0);
    do_exec(16'h0B02);
    chk("R10 other exec", 16'(brk_tag_req), 0);
    do_exec(16'h0B00);
    chk("R10 tagged exec", 16'(brk_tag_req), 1);
    @(negedge clk);
    chk("R10 pulse ends", 16'(brk_tag_req), 0);
    do_arm();
    cyc(16'h0B00, 8'h00, 1, 0, 0);
    do_exec(16'h0B00);
    chk("R10 non-fetch no tag", 16'(brk_tag_req), 0);
    brk_en = 0;
  endtask

  task automatic t_flush();
    trig_mode = 5; cmp_b_addr = 16'h0800;
    do_arm();
    cyc(16'h0800, 8'h12, 1, 0, 0);
    chk("R11 pre cnt", 16'(fifo_cnt), 1);
    do_arm();
    chk("R11 flush cnt", 16'(fifo_cnt), 0);
    chk("R11 flush trig", 16'(trig_flag), 0);
    chk("R11 armed", 16'(armed), 1);
  endtask

  initial begin
    rst_n = 0; bus_valid = 0; bus_addr = 0; bus_data = 0; bus_rd = 0; bus_fetch = 0;
    bus_cof = 0; exec_strobe = 0; exec_addr = 0; cmp_a_addr = 0; cmp_a_dir_en = 0;
    cmp_a_dir = 0; cmp_b_addr = 0; cmp_b_dir_en = 0; cmp_b_dir = 0; cmp_b_data = 0;
    trig_mode = 0; brk_en = 0; brk_tag = 0; arm = 0; disarm = 0; fifo_pop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_seq();
    t_data();
    t_range();
    t_cof();
    t_event();
    t_force();
    t_tag();
    t_flush();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule